// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Transmitter

This block is the transmit half of a clock-synchronous serial port. A host loads bytes into a holding register. The block moves each byte into its frame register and shifts it out least significant bit first. When it is the clock master, the block generates the serial clock from a system-clock divider. When it is a slave, it drives only the data line and follows an external clock, which it first synchronizes to the system clock. Two host-visible flags follow each byte: a buffer-empty flag that drops on a write and rises once the byte is taken for shifting, and a sticky transmit-end flag. Each flag has its own interrupt-request output, gated by its own enable.

A byte written while a frame is in flight waits in the holding register. It is taken at the final clock edge of the current frame, so frames follow each other with no idle gap. An external overrun indication stops any new frame from starting, and dropping the transmit enable aborts the shifter.

The shifter is a two-state machine. TX_IDLE moves to TX_SHIFT when a byte is taken (enable high, buffer full, overrun low). TX_SHIFT stays in TX_SHIFT on the final edge of a frame if another byte is taken (the chain transition). It returns to TX_IDLE on the final edge when no byte is taken, or at once when the enable falls (the abort transition).

Top module: `sync_serial_tx`

## Requirements
- R1: Each frame carries WIDTH (8) bits from the holding register, sent bit 0 first and bit WIDTH-1 last, with 2*WIDTH serial clock edges per frame.
- R2: The serial clock rests at the inverse of `cpol`: high for cpol=0 and low for cpol=1. It is back at that level when a frame ends.
- R3: With cpha=0, `sdo` changes only on odd-numbered clock edges (1, 3, ...), and a receiver samples on even edges. With cpha=1, bit 0 is placed when the byte is taken, later bits change on even edges, and a receiver samples on odd edges.
- R4: In master mode, consecutive serial clock transitions are exactly HALF_DIV system clocks apart.
- R5: A write with `tx_en` high drives `empty_flag` low in the next cycle. When the shifter is idle and no overrun is present, the byte is taken one cycle later and `empty_flag` returns high.
- R6: `irq_empty` is high exactly when `empty_flag` is high and `ie_empty` is high.
- R7: When a byte is waiting at the final edge of a frame, the next frame starts with no gap. Clock spacing stays HALF_DIV across the frame boundary.
- R8: If the final edge of a frame occurs while the buffer is empty, `end_flag` rises in the same cycle as that final clock transition and stays high. `irq_end` equals `end_flag` AND `ie_end`.
- R9: A write with `tx_en` high clears `end_flag` in the next cycle.
- R10: While `ovr_err` is high, no frame starts and a written byte stays in the buffer (`empty_flag` low).
- R11: With `tx_en` low, writes are ignored: the flags stay unchanged. Dropping `tx_en` during a frame returns the clock to its rest level and holds `sdo` at its last value.
- R12: In slave mode (`master`=0), `sck_drive` is low and `sck_out` stays at rest. Data follows `sck_in` edges under the same phase rules, after a SYNC_STAGES-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable |
| master | input | 1 | 1 = block generates serial clock, 0 = follows sck_in |
| cpol | input | 1 | Clock polarity (0: rests high, 1: rests low) |
| cpha | input | 1 | Clock phase select |
| ovr_err | input | 1 | Overrun indication; blocks frame start |
| wr_stb | input | 1 | Host write strobe for the holding register |
| wr_data | input | WIDTH | Host write data |
| ie_empty | input | 1 | Buffer-empty interrupt enable |
| ie_end | input | 1 | Transmit-end interrupt enable |
| sck_in | input | 1 | External serial clock (slave mode) |
| sck_out | output | 1 | Serial clock output |
| sck_drive | output | 1 | High when sck_out should be driven onto the pin |
| sdo | output | 1 | Serial data output |
| empty_flag | output | 1 | Holding register empty |
| end_flag | output | 1 | Sticky transmit-end flag |
| irq_empty | output | 1 | Buffer-empty interrupt request |
| irq_end | output | 1 | Transmit-end interrupt request |

## Verification
The bench builds the block with WIDTH=8, HALF_DIV=3 and SYNC_STAGES=2. An odd divider above one makes clock spacing errors show up in the span between the first and last clock transition of a stream. The short frame lets one chained master stream carry all 256 byte values, and the remaining polarity and phase combinations are each swept in both master and slave mode. The small synchronizer keeps slave-mode latency well inside a bench-driven half period of eight cycles, so the bench can sample data at its own clock edges.

// File: rtl/stx_pkg.sv
`timescale 1ns/1ps
package stx_pkg;

    typedef enum logic {
        TX_IDLE  = 1'b0,
        TX_SHIFT = 1'b1
    } tx_state_t;

endpackage

// File: rtl/stx_edge_src.sv
`timescale 1ns/1ps
module stx_edge_src #(
    parameter int HALF_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic master,
    input  logic sck_in,
    output logic tick
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [DW-1:0]          div_q;
    logic                   wrap;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    assign wrap = (div_q == DW'(HALF_DIV - 1));

    // Master-mode half-period divider, held at zero when not shifting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (!run || wrap)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    // Slave-mode synchronizer chain
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                sync_q[i] <= 1'b0;
            else if (i == 0)
                sync_q[i] <= sck_in;
            else
                sync_q[i] <= sync_q[(i == 0) ? 0 : i - 1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else
            prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign tick = run & (master ? wrap : (sync_q[SYNC_STAGES-1] ^ prev_q));

endmodule

// File: rtl/stx_tx_buffer.sv
`timescale 1ns/1ps
module stx_tx_buffer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             wr_stb,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             load,
    input  logic             frame_end_empty,
    output logic [WIDTH-1:0] buf_data,
    output logic             full,
    output logic             end_flag
);
    logic accept;
    assign accept = tx_en & wr_stb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_data <= '0;
            full     <= 1'b0;
            end_flag <= 1'b0;
        end else begin
            if (accept)
                buf_data <= wr_data;
            if (accept)
                full <= 1'b1;
            else if (load)
                full <= 1'b0;
            if (accept)
                end_flag <= 1'b0;
            else if (frame_end_empty)
                end_flag <= 1'b1;
        end
    end

    a_r5_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> full);
    a_r9_write_clears_end: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !end_flag);
    a_r8_end_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (end_flag && !accept) |=> end_flag);
    a_r11_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !full) |=> !full);

endmodule

// File: rtl/stx_shift_fsm.sv
`timescale 1ns/1ps
module stx_shift_fsm
    import stx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             master,
    input  logic             cpha,
    input  logic             tick,
    input  logic             full,
    input  logic             ovr_err,
    input  logic [WIDTH-1:0] buf_data,
    output logic             load,
    output logic             frame_end_empty,
    output logic             busy,
    output logic             tgl,
    output logic             sdo
);
    localparam int EDGES = 2 * WIDTH;
    localparam int EW    = $clog2(EDGES);
    localparam int BW    = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    tx_state_t        state_q, state_d;
    logic [EW-1:0]    ecnt_q;
    logic [WIDTH-1:0] frame_q;
    logic             can_load;
    logic             last_edge;
    logic [BW-1:0]    idx;
    logic [BW-1:0]    idx_next;

    assign busy      = (state_q == TX_SHIFT);
    assign can_load  = tx_en & full & ~ovr_err;
    assign last_edge = busy & tick & (ecnt_q == EW'(EDGES - 1));
    assign load      = ((state_q == TX_IDLE) & can_load) | (last_edge & can_load);
    assign frame_end_empty = last_edge & tx_en & ~full;
    assign idx       = BW'(ecnt_q >> 1);
    assign idx_next  = BW'(idx + 1'b1);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (load) state_d = TX_SHIFT;
            TX_SHIFT: begin
                if (!tx_en)
                    state_d = TX_IDLE;
                else if (last_edge && !load)
                    state_d = TX_IDLE;
            end
            default:  state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= TX_IDLE;
        else
            state_q <= state_d;
    end

    // Frame register, edge count, clock toggle and data line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ecnt_q  <= '0;
            frame_q <= '0;
            tgl     <= 1'b0;
            sdo     <= 1'b1;
        end else begin
            if (busy && tick && tx_en) begin
                ecnt_q <= ecnt_q + 1'b1;
                if (master)
                    tgl <= ~tgl;
                if (!ecnt_q[0] && !cpha)
                    sdo <= frame_q[idx];
                if (ecnt_q[0] && cpha && !last_edge)
                    sdo <= frame_q[idx_next];
            end
            if (load) begin
                frame_q <= buf_data;
                ecnt_q  <= '0;
                if (cpha)
                    sdo <= buf_data[0];
            end
            if (!tx_en)
                tgl <= 1'b0;
        end
    end

    a_r3_change_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && master && $stable(master) && $stable(cpha) && !$stable(sdo))
            |-> (tgl == ~cpha));
    a_r1_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tick && tx_en && ecnt_q != EW'(EDGES - 1)) |=> busy);

endmodule

// File: rtl/sync_serial_tx.sv
`timescale 1ns/1ps
module sync_serial_tx #(
    parameter int WIDTH       = 8,
    parameter int HALF_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             master,
    input  logic             cpol,
    input  logic             cpha,
    input  logic             ovr_err,
    input  logic             wr_stb,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             ie_empty,
    input  logic             ie_end,
    input  logic             sck_in,
    output logic             sck_out,
    output logic             sck_drive,
    output logic             sdo,
    output logic             empty_flag,
    output logic             end_flag,
    output logic             irq_empty,
    output logic             irq_end
);
    logic [WIDTH-1:0] buf_data;
    logic             full;
    logic             load;
    logic             frame_end_empty;
    logic             busy;
    logic             tgl;
    logic             tick;

    stx_edge_src #(
        .HALF_DIV    (HALF_DIV),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy),
        .master (master),
        .sck_in (sck_in),
        .tick   (tick)
    );

    stx_tx_buffer #(
        .WIDTH (WIDTH)
    ) u_buf (
        .clk             (clk),
        .rst_n           (rst_n),
        .tx_en           (tx_en),
        .wr_stb          (wr_stb),
        .wr_data         (wr_data),
        .load            (load),
        .frame_end_empty (frame_end_empty),
        .buf_data        (buf_data),
        .full            (full),
        .end_flag        (end_flag)
    );

    stx_shift_fsm #(
        .WIDTH (WIDTH)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .tx_en           (tx_en),
        .master          (master),
        .cpha            (cpha),
        .tick            (tick),
        .full            (full),
        .ovr_err         (ovr_err),
        .buf_data        (buf_data),
        .load            (load),
        .frame_end_empty (frame_end_empty),
        .busy            (busy),
        .tgl             (tgl),
        .sdo             (sdo)
    );

    assign sck_out    = ~cpol ^ tgl;
    assign sck_drive  = master;
    assign empty_flag = ~full;
    assign irq_empty  = empty_flag & ie_empty;
    assign irq_end    = end_flag & ie_end;

    a_r2_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (sck_out == ~cpol));
    a_r10_overrun_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_err && !busy) |=> !busy);
    a_r11_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !busy);
    a_r12_slave_clock_rest: assert property (@(posedge clk) disable iff (!rst_n)
        (!master && $past(!master) && $stable(cpol) && !busy) |-> (sck_out == ~cpol));

endmodule

// File: tb/sim_sync_serial_tx.sv
`timescale 1ns/1ps
module sim_sync_serial_tx;
    localparam int W    = 8;
    localparam int HALF = 3;
    localparam int SYNC = 2;
    localparam int HS   = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 1'b0, master = 1'b1, cpol = 1'b0, cpha = 1'b0, ovr_err = 1'b0;
    logic wr_stb = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic ie_empty = 1'b0, ie_end = 1'b0, sck_in = 1'b1;
    logic sck_out, sck_drive, sdo, empty_flag, end_flag, irq_empty, irq_end;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sync_serial_tx #(.WIDTH(W), .HALF_DIV(HALF), .SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .master(master), .cpol(cpol),
        .cpha(cpha), .ovr_err(ovr_err), .wr_stb(wr_stb), .wr_data(wr_data),
        .ie_empty(ie_empty), .ie_end(ie_end), .sck_in(sck_in), .sck_out(sck_out),
        .sck_drive(sck_drive), .sdo(sdo), .empty_flag(empty_flag), .end_flag(end_flag),
        .irq_empty(irq_empty), .irq_end(irq_end)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Receiver model watching the master clock
    logic       prev_sck = 1'b1;
    int         edge_n = 0, tog_cnt = 0, first_tog = 0, last_tog = 0;
    int         rx_n = 0, exp_total = 0;
    logic [7:0] rx_sh = '0;
    logic [7:0] rx_mem [0:255];

    always @(negedge clk) begin
        if (rst_n && sck_out !== prev_sck) begin
            tog_cnt++;
            if (tog_cnt == 1) first_tog = cyc;
            last_tog = cyc;
            edge_n++;
            if ((cpha == 1'b0) ? (edge_n % 2 == 0) : (edge_n % 2 == 1))
                rx_sh[(edge_n - 1) / 2] = sdo;
            if (edge_n == 2 * W) begin
                chk("R8 end flag at final edge", int'(end_flag), int'(rx_n + 1 == exp_total));
                if (rx_n < 256) rx_mem[rx_n] = rx_sh;
                rx_n++;
                edge_n = 0;
            end
        end
        prev_sck = sck_out;
    end

    task automatic mon_clear();
        @(negedge clk);
        edge_n = 0; tog_cnt = 0; rx_n = 0;
    endtask

    task automatic wr_byte(input logic [7:0] b);
        @(negedge clk);
        wr_stb = 1'b1; wr_data = b;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic wait_empty();
        for (int i = 0; i < 2000 && !empty_flag; i++) @(negedge clk);
        chk("R5 buffer drained", int'(empty_flag), 1);
    endtask

    task automatic wait_end();
        for (int i = 0; i < 5000 && !end_flag; i++) @(negedge clk);
        chk("R8 end flag reached", int'(end_flag), 1);
    endtask

    task automatic master_stream(input logic cp, input logic ph, input int n,
                                 input int mul, input int add);
        @(negedge clk);
        master = 1'b1; cpol = cp; cpha = ph;
        repeat (3) @(negedge clk);
        mon_clear();
        exp_total = n;
        for (int i = 0; i < n; i++) begin
            wait_empty();
            wr_byte(8'((i * mul + add) & 255));
        end
        wait_end();
        repeat (2) @(negedge clk);
        chk("R1 frame count", rx_n, n);
        for (int i = 0; i < n && i < 256; i++)
            chk(ph ? "R1 R3 byte cpha1" : "R1 R3 byte cpha0", int'(rx_mem[i]), (i * mul + add) & 255);
        chk("R4 transition count", tog_cnt, 2 * W * n);
        chk("R4 R7 gapless span", last_tog - first_tog, (2 * W * n - 1) * HALF);
        chk("R2 rest level", int'(sck_out), int'(~cp & 1'b1));
    endtask

    task automatic slave_frame(input logic cp, input logic ph, input logic [7:0] b);
        logic [7:0] got;
        @(negedge clk);
        master = 1'b0; cpol = cp; cpha = ph; sck_in = ~cp;
        repeat (10) @(negedge clk);
        mon_clear();
        wr_byte(b);
        wait_empty();
        repeat (4) @(negedge clk);
        got = '0;
        for (int e = 1; e <= 2 * W; e++) begin
            repeat (HS) @(negedge clk);
            if ((ph == 1'b0) ? (e % 2 == 0) : (e % 2 == 1))
                got[(e - 1) / 2] = sdo;
            sck_in = ~sck_in;
        end
        repeat (10) @(negedge clk);
        chk("R12 slave byte", int'(got), int'(b));
        chk("R12 no clock drive", int'(sck_drive), 0);
        chk("R12 clock at rest", tog_cnt, 0);
        chk("R8 slave end flag", int'(end_flag), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R4 watchdog actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic s;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5 reset empty", int'(empty_flag), 1);
        chk("R8 reset end", int'(end_flag), 0);
        chk("R6 reset irq_empty", int'(irq_empty), 0);
        chk("R8 reset irq_end", int'(irq_end), 0);
        chk("R2 reset rest level", int'(sck_out), 1);
        tx_en = 1'b1;

        // Exhaustive byte sweep in one chained stream, then other modes
        master_stream(1'b0, 1'b0, 256, 1, 0);
        master_stream(1'b0, 1'b1, 24, 37, 11);
        master_stream(1'b1, 1'b0, 24, 53, 22);
        master_stream(1'b1, 1'b1, 24, 91, 33);

        // R5 R6 R8 R9 flags and requests
        master = 1'b1; cpol = 1'b0; cpha = 1'b0;
        ie_end = 1'b1; ie_empty = 1'b1;
        @(negedge clk);
        chk("R8 irq_end enabled", int'(irq_end), 1);
        ie_end = 1'b0;
        @(negedge clk);
        chk("R8 irq_end masked", int'(irq_end), 0);
        chk("R6 irq_empty enabled", int'(irq_empty), 1);
        ie_end = 1'b1;
        mon_clear();
        exp_total = 1;
        wr_byte(8'hA5);
        chk("R5 empty drops", int'(empty_flag), 0);
        chk("R6 irq_empty drops", int'(irq_empty), 0);
        chk("R9 end cleared", int'(end_flag), 0);
        @(negedge clk);
        chk("R5 empty returns", int'(empty_flag), 1);
        wait_end();
        repeat (2) @(negedge clk);
        chk("R1 single byte", int'(rx_mem[0]), 8'hA5);
        ie_empty = 1'b0;
        @(negedge clk);
        chk("R6 irq_empty masked", int'(irq_empty), 0);

        // R10 overrun blocks start
        mon_clear();
        exp_total = 1;
        ovr_err = 1'b1;
        wr_byte(8'h3C);
        repeat (40) @(negedge clk);
        chk("R10 byte held", int'(empty_flag), 0);
        chk("R10 no clock", tog_cnt, 0);
        ovr_err = 1'b0;
        wait_end();
        repeat (2) @(negedge clk);
        chk("R10 sent after release", int'(rx_mem[0]), 8'h3C);

        // R11 writes ignored while disabled
        mon_clear();
        tx_en = 1'b0;
        wr_byte(8'h55);
        repeat (5) @(negedge clk);
        chk("R11 empty unchanged", int'(empty_flag), 1);
        chk("R11 end unchanged", int'(end_flag), 1);
        chk("R11 no clock", tog_cnt, 0);
        tx_en = 1'b1;

        // R11 abort mid-frame with clock resting low
        @(negedge clk);
        cpol = 1'b1;
        repeat (3) @(negedge clk);
        mon_clear();
        exp_total = 99;
        wr_byte(8'h0F);
        for (int i = 0; i < 500 && tog_cnt < 5; i++) @(negedge clk);
        tx_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R11 clock back at rest", int'(sck_out), 0);
        s = sdo;
        repeat (10) @(negedge clk);
        chk("R11 data held", int'(sdo), int'(s));
        chk("R11 clock still at rest", int'(sck_out), 0);
        tx_en = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 end stays clear after abort", int'(end_flag), 0);

        // R12 slave mode in all four clock modes
        for (int m = 0; m < 4; m++)
            for (int k = 0; k < 4; k++)
                slave_frame(m[1], m[0], 8'((k * 71 + m * 29 + 5) & 255));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule